// File: doc/BRIEF.md
# Priority Microtask Switch Controller

A set of hardware microcode tasks shares a single micromachine. This controller decides which task owns that micromachine and supplies the micro-PC from which the next microinstruction is fetched. A task runs sequentially, and no other task can run, until one of its microinstructions carries the task-switch code in its F1 field. On that instruction the controller samples the wakeup lines and picks the awake task with the highest priority. Task 15 has the highest priority and task 0 the lowest. Task 0 always counts as awake, so some task is always runnable.

When the chosen task differs from the running one, the controller stores the outgoing task's next micro-PC in a per-task save array. In the following cycle it fetches from the incoming task's saved micro-PC. Otherwise the running task continues and fetches from the next micro-PC that the micromachine presents. Reset starts task 0 at micro-PC 0 and loads each save entry with its own task number. A task that has never run therefore starts at the micro-PC equal to its number.

Top module: `mts_switch_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it, the current task is 0 and the fetch micro-PC is 0. After reset, the first switch into task k fetches from micro-PC k.
- R2: When F1 is any value other than 2, the task stays the same and the next fetch micro-PC equals the next micro-PC presented in that cycle. The wakeup lines have no effect in that cycle.
- R3: When F1 equals 2, the task in the following cycle is the highest-numbered task whose wakeup bit was 1 in the TASK cycle. Task 15 has the top priority.
- R4: When F1 equals 2, the current task's own wakeup bit is 1 and no higher-numbered wakeup bit is 1, the task continues and fetches from the presented next micro-PC. Lower-priority awake tasks never preempt it.
- R5: On a switch, the fetch micro-PC in the following cycle is the value saved for the incoming task.
- R6: On a switch, the outgoing task's presented next micro-PC is saved. A later switch back into that task resumes at that value.
- R7: Wakeup bit 0 is ignored, because task 0 is always treated as awake. A TASK instruction with every wakeup bit at 0 selects task 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wake_i | input | 16 | Wakeup request per task, bit n for task n |
| f1_i | input | 4 | F1 field of the current microinstruction; 2 requests a task switch |
| next_upc_i | input | 10 | Next micro-PC of the running task |
| task_o | output | 4 | Number of the running task |
| fetch_upc_o | output | 10 | Micro-PC to fetch this cycle |

## Verification
The hardest case to reach is a resume from a save entry that was written by an earlier switch rather than by reset. The task must leave, and later be chosen again, when its wakeup is the highest one still asserted. The stimulus moves up from task 0 to task 8 and then to task 15. It then drops the wakeups so that control falls back through task 8 to task 0, and each fall-back must return the micro-PC that was saved on the way up. A second reset in mid-run then shows that those saved values are cleared back to the task numbers.

// File: rtl/mts_pkg.sv
package mts_pkg;
  // F1 code that requests a task switch
  localparam int F1_TASK_CODE = 2;

  function automatic logic f1_is_task(input logic [3:0] f1);
    return f1 == 4'(F1_TASK_CODE);
  endfunction

  // A switch happens when a TASK instruction names a task other than the running one
  function automatic logic is_switch(input logic task_req, input logic [3:0] cur,
                                     input logic [3:0] win);
    return task_req && (cur != win);
  endfunction
endpackage

// File: rtl/mts_prio_pick.sv
module mts_prio_pick #(
  parameter int N  = 16,
  parameter int TW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic [TW-1:0] win_o
);
  // Highest index wins; index 0 is always a candidate
  logic [N-1:0] req_eff;
  assign req_eff = {req_i[N-1:1], 1'b1};

  always_comb begin
    win_o = '0;
    for (int i = 0; i < N; i++) begin
      if (req_eff[i]) win_o = TW'(i);
    end
  end
endmodule

// File: rtl/mts_upc_store.sv
module mts_upc_store #(
  parameter int N  = 16,
  parameter int TW = $clog2(N),
  parameter int UW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [TW-1:0] wr_idx,
  input  logic [UW-1:0] wr_data,
  input  logic [TW-1:0] rd_idx,
  output logic [UW-1:0] rd_data
);
  logic [UW-1:0] slot [N];

  for (genvar g = 0; g < N; g++) begin : g_slot
    localparam logic [UW-1:0] INIT = UW'(g);
    always_ff @(posedge clk) begin
      if (!rst_n)                            slot[g] <= INIT;
      else if (wr_en && wr_idx == TW'(g))    slot[g] <= wr_data;
    end
  end

  assign rd_data = slot[rd_idx];
endmodule

// File: rtl/mts_task_state.sv
module mts_task_state #(
  parameter int TW = 4,
  parameter int UW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          switch_i,
  input  logic [TW-1:0] win_i,
  input  logic [UW-1:0] restore_upc_i,
  input  logic [UW-1:0] next_upc_i,
  output logic [TW-1:0] task_o,
  output logic [UW-1:0] upc_o
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      task_o <= '0;
      upc_o  <= '0;
    end else if (switch_i) begin
      task_o <= win_i;
      upc_o  <= restore_upc_i;
    end else begin
      upc_o  <= next_upc_i;
    end
  end
endmodule

// File: rtl/mts_switch_ctrl.sv
module mts_switch_ctrl #(
  parameter int N_TASK = 16,
  parameter int UPC_W  = 10,
  parameter int F1_W   = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [N_TASK-1:0]          wake_i,
  input  logic [F1_W-1:0]            f1_i,
  input  logic [UPC_W-1:0]           next_upc_i,
  output logic [$clog2(N_TASK)-1:0]  task_o,
  output logic [UPC_W-1:0]           fetch_upc_o
);
  import mts_pkg::*;
  localparam int TW = $clog2(N_TASK);

  // Named internal events
  logic          task_req_w;
  logic [TW-1:0] winner_w;
  logic          switch_w;
  logic [UPC_W-1:0] restore_upc_w;

  assign task_req_w = f1_is_task(4'(f1_i));
  assign switch_w   = is_switch(task_req_w, 4'(task_o), 4'(winner_w));

  mts_prio_pick #(.N(N_TASK), .TW(TW)) u_pick (
    .req_i (wake_i),
    .win_o (winner_w)
  );

  mts_upc_store #(.N(N_TASK), .TW(TW), .UW(UPC_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (switch_w),
    .wr_idx  (task_o),
    .wr_data (next_upc_i),
    .rd_idx  (winner_w),
    .rd_data (restore_upc_w)
  );

  mts_task_state #(.TW(TW), .UW(UPC_W)) u_state (
    .clk           (clk),
    .rst_n         (rst_n),
    .switch_i      (switch_w),
    .win_i         (winner_w),
    .restore_upc_i (restore_upc_w),
    .next_upc_i    (next_upc_i),
    .task_o        (task_o),
    .upc_o         (fetch_upc_o)
  );
endmodule

// File: rtl/mts_switch_chk.sv
module mts_switch_chk #(
  parameter int N_TASK = 16,
  parameter int UPC_W  = 10,
  parameter int F1_W   = 4,
  parameter int TW     = $clog2(N_TASK)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_TASK-1:0] wake_i,
  input logic [F1_W-1:0]   f1_i,
  input logic [UPC_W-1:0]  next_upc_i,
  input logic [TW-1:0]     task_o,
  input logic [UPC_W-1:0]  fetch_upc_o,
  input logic              switch_w,
  input logic [TW-1:0]     winner_w,
  input logic [UPC_W-1:0]  restore_upc_w
);
  // R2
  hold_no_task_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (f1_i != F1_W'(2)) |=> (task_o == $past(task_o)) && (fetch_upc_o == $past(next_upc_i)));

  // R3
  no_higher_awake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (f1_i == F1_W'(2)) |=> (($past(wake_i) >> ({1'b0, task_o} + (TW+1)'(1))) == '0));

  // R4
  own_wake_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((f1_i == F1_W'(2)) && wake_i[task_o]) |=> (task_o >= $past(task_o)));

  // R5
  restore_upc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    switch_w |=> (fetch_upc_o == $past(restore_upc_w)) && (task_o == $past(winner_w)));

  // R3
  switch_differs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    switch_w |-> (winner_w != task_o));
endmodule

bind mts_switch_ctrl mts_switch_chk #(.N_TASK(N_TASK), .UPC_W(UPC_W), .F1_W(F1_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wake_i        (wake_i),
  .f1_i          (f1_i),
  .next_upc_i    (next_upc_i),
  .task_o        (task_o),
  .fetch_upc_o   (fetch_upc_o),
  .switch_w      (switch_w),
  .winner_w      (winner_w),
  .restore_upc_w (restore_upc_w)
);

// File: tb/test_mts_switch_ctrl.sv
`timescale 1ns/1ps
module test_mts_switch_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] wake_i = '0;
  logic [3:0]  f1_i = '0;
  logic [9:0]  next_upc_i = '0;
  logic [3:0]  task_o;
  logic [9:0]  fetch_upc_o;

  int n_run  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  mts_switch_ctrl i_mts_switch_ctrl (
    .clk(clk), .rst_n(rst_n), .wake_i(wake_i), .f1_i(f1_i),
    .next_upc_i(next_upc_i), .task_o(task_o), .fetch_upc_o(fetch_upc_o)
  );

  task automatic check(input string req, input logic [3:0] et, input logic [9:0] eu);
    n_run++;
    if (task_o !== et || fetch_upc_o !== eu) begin
      n_fail++;
      $display("FAIL %s: task=%0d upc=0x%0h, expected task=%0d upc=0x%0h",
               req, task_o, fetch_upc_o, et, eu);
    end
  endtask

  // One microinstruction: drive at negedge, sample shortly after the next rising edge
  task automatic step(input logic [3:0] f1, input logic [15:0] wk, input logic [9:0] nu);
    @(negedge clk);
    f1_i = f1; wake_i = wk; next_upc_i = nu;
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; f1_i = '0; wake_i = '0; next_upc_i = '0;
    repeat (2) @(posedge clk);
    #1;
    check("R1 in reset", 4'd0, 10'd0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    step(4'd0, 16'h0000, 10'h000);
    check("R1 after reset", 4'd0, 10'd0);
  endtask

  task automatic t_no_task();
    step(4'd0, 16'hFFFF, 10'h005);
    check("R2 f1=0 wake all", 4'd0, 10'h005);
    step(4'd3, 16'hFFFF, 10'h006);
    check("R2 f1=3", 4'd0, 10'h006);
    step(4'd10, 16'h8000, 10'h007);
    check("R2 f1=10", 4'd0, 10'h007);
  endtask

  task automatic t_switch_up();
    step(4'd2, 16'h0110, 10'h021);
    check("R3 R5 R1 switch to 8 from reset entry", 4'd8, 10'h008);
    step(4'd2, 16'h0128, 10'h030);
    check("R4 lower wakes do not preempt", 4'd8, 10'h030);
    step(4'd2, 16'h8100, 10'h055);
    check("R3 switch to 15", 4'd15, 10'h00F);
  endtask

  task automatic t_fall_back();
    step(4'd2, 16'h0100, 10'h077);
    check("R6 resume task 8", 4'd8, 10'h055);
    step(4'd2, 16'h0000, 10'h040);
    check("R7 R6 none awake -> task 0", 4'd0, 10'h021);
  endtask

  task automatic t_wake_timing();
    step(4'd0, 16'h8000, 10'h022);
    check("R2 wake ignored without TASK", 4'd0, 10'h022);
    step(4'd2, 16'h0000, 10'h023);
    check("R7 task 0 continues", 4'd0, 10'h023);
    step(4'd2, 16'h8000, 10'h024);
    check("R6 resume task 15", 4'd15, 10'h077);
  endtask

  task automatic t_reset_clears();
    do_reset();
    step(4'd0, 16'h0000, 10'h000);
    check("R1 after second reset", 4'd0, 10'd0);
    step(4'd2, 16'h1001, 10'h111);
    check("R1 R3 task 12 fresh entry", 4'd12, 10'h00C);
    step(4'd2, 16'h9000, 10'h112);
    check("R1 task 15 entry cleared", 4'd15, 10'h00F);
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_no_task();
    t_switch_up();
    t_fall_back();
    t_wake_timing();
    t_reset_clears();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule